// File: doc/BRIEF.md
# Status-Decoded Bus Cycle Controller

This block sits next to a processor that announces each bus transaction with a three-bit status code. While the controller is idle and the code moves off the passive value, it captures the code as the cycle type. It then steps through the bus states T1, T2, T3, any wait states, and T4, and drives the bus command strobes that match the captured type.

The controller pulses an address latch enable during T1. Downstream logic latches the address and status on the falling edge of that pulse. Read-type commands (memory read, instruction fetch, I/O read, interrupt acknowledge) open one state earlier than write commands. All commands are active low and stay asserted to the end of T4. A slow device holds the ready input low to stretch the cycle by whole clocks. Halt cycles run the full state sequence with the latch pulse but drive no command.

Status codes used throughout (bit 2 first): 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write, 111 passive.

Top module: `bus_cycle_ctl`

## Requirements
- R1: `cyc_type_o` holds the captured status code from T1 through T4. It reads 111 in every idle clock.
- R2: A cycle starts (T1 in the next clock) when the controller is idle, `status_i` is non-passive, and `status_i` was passive at the previous clock edge. A non-passive code held across a cycle and into idle starts no second cycle.
- R3: `ale_o` is high for exactly the one clock of T1 and low in every other clock.
- R4: Read-type strobes are low from T2 through the end of T4, including wait states: `inta_no` for code 000, `io_rd_no` for 001, `mem_rd_no` for 100 and 101.
- R5: Write strobes are low from T3 through the end of T4, including wait states: `io_wr_no` for code 010, `mem_wr_no` for 110.
- R6: A halt cycle (011) runs T1 to T4 with the `ale_o` pulse and asserts no strobe.
- R7: `ready_i` is sampled at the rising edge that ends T3 and at the edge that ends each wait state. Each low sample adds exactly one wait state. `ready_i` has no effect in T1, T2 or T4.
- R8: Changes of `status_i` after the start edge do not alter the cycle type, length or strobes of the running cycle.
- R9: At most one strobe is low at any time, and all strobes are high in idle and T1.
- R10: While `rst_ni` is low, `ale_o` is low, all strobes are high and `cyc_type_o` is 111, taking effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Processor bus status code |
| ready_i | input | 1 | Device ready; low inserts wait states |
| ale_o | output | 1 | Address latch enable, high in T1 |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| mem_rd_no | output | 1 | Memory read / fetch strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| cyc_type_o | output | 3 | Captured cycle type, 111 when idle |

## Verification
Two things can fall in one cycle: the end of T4 and the processor's status for the next transaction. The next cycle may only start after a passive code has been seen, so the bench holds the old code, or switches to another non-passive code, in the clock right after T1. It then checks that the type stays frozen and that no second latch pulse appears in idle. The bench also drives ready low in T1, T2 and T4, where ready must be ignored, alongside the real wait requests at T3 and in wait states. Each sweep point is judged by comparing the clock-by-clock strobe, latch and type pattern with the pattern predicted from the code and the wait count.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned STAT_W  = 3;
  localparam int unsigned NUM_CMD = 5;

  // command vector bit positions
  localparam int unsigned CMD_INTA   = 0;
  localparam int unsigned CMD_IO_RD  = 1;
  localparam int unsigned CMD_IO_WR  = 2;
  localparam int unsigned CMD_MEM_RD = 3;
  localparam int unsigned CMD_MEM_WR = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IO_RD   = 3'b001,
    ST_IO_WR   = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEM_RD  = 3'b101,
    ST_MEM_WR  = 3'b110,
    ST_PASSIVE = 3'b111
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_TW,
    PH_T4
  } phase_e;

  typedef struct packed {
    logic [NUM_CMD-1:0] sel;
    logic               is_write;
  } cls_t;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
(
  input  stat_e code_i,
  output cls_t  cls_o
);
  always_comb begin
    cls_o = '0;
    unique case (code_i)
      ST_INTA:   cls_o.sel[CMD_INTA]   = 1'b1;
      ST_IO_RD:  cls_o.sel[CMD_IO_RD]  = 1'b1;
      ST_IO_WR:  begin
        cls_o.sel[CMD_IO_WR] = 1'b1;
        cls_o.is_write       = 1'b1;
      end
      ST_FETCH,
      ST_MEM_RD: cls_o.sel[CMD_MEM_RD] = 1'b1;
      ST_MEM_WR: begin
        cls_o.sel[CMD_MEM_WR] = 1'b1;
        cls_o.is_write        = 1'b1;
      end
      default:   cls_o = '0; // halt, passive: no command
    endcase
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              ready_i,
  output phase_e            phase_o,
  output stat_e             code_o
);
  phase_e phase_q;
  stat_e  code_q;
  logic   passive_q;
  logic   is_passive;
  logic   start;

  assign is_passive = (stat_e'(status_i) == ST_PASSIVE);
  // start only on a passive -> active transition
  assign start      = (phase_q == PH_IDLE) && !is_passive && passive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      code_q    <= ST_PASSIVE;
      passive_q <= 1'b1;
    end else begin
      passive_q <= is_passive;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_T1;
          code_q  <= stat_e'(status_i);
        end
        PH_T1: phase_q <= PH_T2;
        PH_T2: phase_q <= PH_T3;
        PH_T3,
        PH_TW: phase_q <= ready_i ? PH_T4 : PH_TW;
        PH_T4: begin
          phase_q <= PH_IDLE;
          code_q  <= ST_PASSIVE;
        end
        default: begin
          phase_q <= PH_IDLE;
          code_q  <= ST_PASSIVE;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign code_o  = code_q;
endmodule

// File: rtl/bcc_cmd.sv
module bcc_cmd
  import bcc_pkg::*;
(
  input  phase_e             phase_i,
  input  cls_t               cls_i,
  output logic               ale_o,
  output logic [NUM_CMD-1:0] cmd_no
);
  logic early_win;
  logic late_win;

  assign ale_o     = (phase_i == PH_T1);
  assign early_win = (phase_i == PH_T2) || (phase_i == PH_T3) ||
                     (phase_i == PH_TW) || (phase_i == PH_T4);
  assign late_win  = (phase_i == PH_T3) || (phase_i == PH_TW) ||
                     (phase_i == PH_T4);

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    assign cmd_no[i] = ~(cls_i.sel[i] & (cls_i.is_write ? late_win : early_win));
  end
endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
  import bcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              ready_i,
  output logic              ale_o,
  output logic              inta_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic [STAT_W-1:0] cyc_type_o
);
  phase_e             phase;
  stat_e              code;
  cls_t               cls;
  logic [NUM_CMD-1:0] cmd_n;

  bcc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .ready_i  (ready_i),
    .phase_o  (phase),
    .code_o   (code)
  );

  bcc_decode u_dec (
    .code_i (code),
    .cls_o  (cls)
  );

  bcc_cmd u_cmd (
    .phase_i (phase),
    .cls_i   (cls),
    .ale_o   (ale_o),
    .cmd_no  (cmd_n)
  );

  assign inta_no    = cmd_n[CMD_INTA];
  assign io_rd_no   = cmd_n[CMD_IO_RD];
  assign io_wr_no   = cmd_n[CMD_IO_WR];
  assign mem_rd_no  = cmd_n[CMD_MEM_RD];
  assign mem_wr_no  = cmd_n[CMD_MEM_WR];
  assign cyc_type_o = code;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_o,
  input logic       inta_no,
  input logic       io_rd_no,
  input logic       io_wr_no,
  input logic       mem_rd_no,
  input logic       mem_wr_no,
  input logic [2:0] cyc_type_o
);
  logic [4:0] cmd_n;
  logic       rd_n_all;
  logic       wr_n_all;

  assign cmd_n    = {mem_wr_no, mem_rd_no, io_wr_no, io_rd_no, inta_no};
  assign rd_n_all = inta_no & io_rd_no & mem_rd_no;
  assign wr_n_all = io_wr_no & mem_wr_no;

  a_r3_ale_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  a_r3_ale_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (cyc_type_o != 3'b111));

  a_r9_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cmd_n));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_type_o == 3'b111 || ale_o) |-> (&cmd_n));

  a_r4_read_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_all) |-> $past(ale_o));

  a_r5_write_two_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_all) |-> $past(ale_o, 2));

  a_r1_type_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_type_o != 3'b111 && $past(cyc_type_o) != 3'b111) |-> $stable(cyc_type_o));

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!ale_o && (&cmd_n) && cyc_type_o == 3'b111));
endmodule

bind bus_cycle_ctl bcc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ale_o      (ale_o),
  .inta_no    (inta_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .cyc_type_o (cyc_type_o)
);

// File: tb/bus_cycle_ctl_tb.sv
module bus_cycle_ctl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [2:0] status_i = 3'b111;
  logic       ready_i = 1'b1;
  logic       ale_o;
  logic       inta_no, io_rd_no, io_wr_no, mem_rd_no, mem_wr_no;
  logic [2:0] cyc_type_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  bus_cycle_ctl u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_i),
    .ready_i    (ready_i),
    .ale_o      (ale_o),
    .inta_no    (inta_no),
    .io_rd_no   (io_rd_no),
    .io_wr_no   (io_wr_no),
    .mem_rd_no  (mem_rd_no),
    .mem_wr_no  (mem_wr_no),
    .cyc_type_o (cyc_type_o)
  );

  function automatic logic [4:0] strb_now();
    return {mem_wr_no, mem_rd_no, io_wr_no, io_rd_no, inta_no};
  endfunction

  // expected strobe vector {mem_wr, mem_rd, io_wr, io_rd, inta}, phase p from T1=0
  function automatic logic [4:0] exp_strb(int code, int p, int w);
    logic [4:0] v = 5'b11111;
    int bitn = -1;
    bit wr = 1'b0;
    case (code)
      0: bitn = 0;
      1: bitn = 1;
      2: begin bitn = 2; wr = 1'b1; end
      4, 5: bitn = 3;
      6: begin bitn = 4; wr = 1'b1; end
      default: bitn = -1;
    endcase
    if (bitn >= 0 && p <= 3 + w && p >= (wr ? 2 : 1)) v[bitn] = 1'b0;
    return v;
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // run one bus cycle; called and returning at a falling edge
  task automatic run_cycle(int code, int w, logic [2:0] mid_code);
    status_i = 3'(code);
    ready_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    for (int p = 0; p <= 4 + w; p++) begin
      chk("R3 ale", {4'b0, ale_o}, {4'b0, (p == 0)});
      chk("R1 R8 type", {2'b0, cyc_type_o}, {2'b0, (p <= 3 + w) ? 3'(code) : 3'b111});
      chk((code == 3) ? "R6 halt" : "R4 R5 R7 R9 strobes", strb_now(), exp_strb(code, p, w));
      if (p == 0) status_i = mid_code;
      if (p < 2) ready_i = (w % 2 == 0);          // ignored in T1/T2
      else if (p == 3 + w) ready_i = (w != 1);    // ignored in T4
      else ready_i = (p >= 2 + w);
      if (p < 4 + w) begin
        @(posedge clk_i);
        @(negedge clk_i);
      end
    end
    // R2: held non-passive status must not start another cycle
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R2 no restart", {1'b0, ale_o, cyc_type_o}, {1'b0, 1'b0, 3'b111});
    end
    status_i = 3'b111;
    ready_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    #1;
    chk("R10 reset", {1'b0, ale_o, cyc_type_o}, {1'b0, 1'b0, 3'b111});
    chk("R10 reset strobes", strb_now(), 5'b11111);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: passive status starts nothing
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R2 passive idle", {1'b0, ale_o, cyc_type_o}, {1'b0, 1'b0, 3'b111});
    end
    // sweep: all non-passive codes, 0..3 wait states, status held/switched/passive
    for (int c = 0; c < 7; c++) begin
      for (int w = 0; w < 4; w++) begin
        logic [2:0] mc;
        case (w)
          0: mc = 3'b111;
          1: mc = 3'(c);
          2: mc = 3'((c + 1) % 7);
          default: mc = 3'b111;
        endcase
        run_cycle(c, w, mc);
      end
    end
    // R10: asynchronous reset in the middle of a write cycle
    status_i = 3'b110;
    @(posedge clk_i);
    @(negedge clk_i);
    status_i = 3'b111;
    ready_i  = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R5 write low before reset", strb_now(), 5'b01111);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R10 async reset", {1'b0, ale_o, cyc_type_o}, {1'b0, 1'b0, 3'b111});
    chk("R10 async reset strobes", strb_now(), 5'b11111);
    @(negedge clk_i);
    rst_ni  = 1'b1;
    ready_i = 1'b1;
    @(negedge clk_i);
    chk("R10 stays idle", {1'b0, ale_o, cyc_type_o}, {1'b0, 1'b0, 3'b111});
    run_cycle(5, 2, 3'b111);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule